// File: doc/BRIEF.md
# Pin-Selectable Audio Delay Line

This block turns a stream of 8-bit converter samples into the same stream delayed by a fixed number of sample periods. A free-running clock is divided down so that one sample strobe is produced every `DIV` clocks. On every strobe the block stores the sample presented by the converter into a circular buffer, and it fetches the sample stored a chosen number of strobes earlier. The fetched sample goes to a DAC output register.

Three static pins pick one of eight delay lengths. Each length is a whole multiple of one eighth of the buffer depth. The pins do not carry binary weights in their numbering order. With the defaults (divide by 32, 2048-entry buffer) and a 455 kHz clock, the sample rate is about 14.22 kHz. The shortest setting is then about 18 ms and the longest about 144 ms.

After reset the output holds the mid-scale code. It leaves mid-scale only once the whole buffer has been written, so the first delayed samples are always genuine history.

Top module: `adly_top`

## Requirements
- R1: `smp_strobe` is high for exactly one clock in every `DIV` clocks. The first strobe comes within `DIV`+4 clocks of `rst_n` rising.
- R2: On each strobe the value on `smp_in` is written into a circular buffer of 2^`AW` entries. The write position advances by one per strobe and wraps.
- R3: Let the current strobe be number k, counted from reset. Once the buffer is full, the output produced for strobe k is the sample written at strobe k−N, where N is the selected delay.
- R4: The delay is N = (idx+1)·2^`AW`/8. With defaults this gives 256, 512, … 2048 samples.
- R5: The select index is idx = {`dly_pin1`, `dly_pin2`, `dly_pin0`}. `dly_pin1` carries weight 4, `dly_pin2` carries weight 2 and `dly_pin0` carries weight 1.
- R6: While reset is active, `dac_out` is 0x80 and `smp_strobe` is low. After reset, `dac_out` stays 0x80 until 2^`AW` samples have been written before the current strobe.
- R7: `dac_out` changes only on the clock after a strobe. Between updates it holds its value.
- R8: A change on the select pins takes effect at the next strobe. No older setting is used after that strobe.
- R9: At the maximum setting the read happens before the write to the same location, so the oldest stored sample is output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_in | input | DW | Sample from the converter, taken on the strobe cycle |
| dly_pin0 | input | 1 | Delay select, weight 1 |
| dly_pin1 | input | 1 | Delay select, weight 4 |
| dly_pin2 | input | 1 | Delay select, weight 2 |
| smp_strobe | output | 1 | One-clock sample strobe toward the converter |
| dac_out | output | DW | Delayed sample register toward the DAC |

## Verification
The bench builds the block with `DIV`=4 and `AW`=6: a 64-entry buffer and delays of 8 to 64 samples. This lets it run through every one of the eight settings, many pointer wraps, the fill boundary and a mid-run reset in a few thousand clocks. The divider's strobe spacing and the read-before-write case at the full-depth setting stay exactly as they are at the default sizes.

// File: rtl/adly_pkg.sv
package adly_pkg;
  // Pin-to-index mapping: dly_pin1 is weight 4, dly_pin2 weight 2, dly_pin0 weight 1.
  function automatic logic [2:0] sel_index(input logic p0, input logic p1, input logic p2);
    return {p1, p2, p0};
  endfunction
endpackage

// File: rtl/adly_rst_sync.sv
module adly_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_n_sync = sh_q[1];
endmodule

// File: rtl/adly_tick_gen.sv
module adly_tick_gen #(
  parameter int DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (cnt_q == LAST) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign strobe = (cnt_q == LAST);

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST); // R1
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe); // R1
endmodule

// File: rtl/adly_ring_ptr.sv
module adly_ring_ptr #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  output logic [AW-1:0] wr_ptr,
  output logic          full
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW:0] FULL_CNT = (AW+1)'(DEPTH);

  logic [AW-1:0] ptr_q, ptr_d;
  logic [AW:0]   fill_q, fill_d;

  always_comb begin
    ptr_d  = ptr_q;
    fill_d = fill_q;
    if (step) begin
      ptr_d = ptr_q + 1'b1;
      if (fill_q != FULL_CNT) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      fill_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      fill_q <= fill_d;
    end
  end

  assign wr_ptr = ptr_q;
  assign full   = (fill_q == FULL_CNT);

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(ptr_q)); // R2
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= FULL_CNT); // R6
  AST_FULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> full); // R6
endmodule

// File: rtl/adly_sample_ram.sv
module adly_sample_ram #(
  parameter int DW = 8,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          acc_en,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  // Read and write share one enable; the read returns the old contents.
  always_ff @(posedge clk) begin
    if (acc_en) begin
      rdata_q     <= mem[raddr];
      mem[waddr]  <= wdata;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/adly_top.sv
module adly_top #(
  parameter int DIV = 32,
  parameter int DW  = 8,
  parameter int AW  = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] smp_in,
  input  logic          dly_pin0,
  input  logic          dly_pin1,
  input  logic          dly_pin2,
  output logic          smp_strobe,
  output logic [DW-1:0] dac_out
);
  import adly_pkg::*;

  localparam int DEPTH = 1 << AW;
  localparam int STEP  = DEPTH / 8;
  localparam logic [DW-1:0] MID = DW'(1) << (DW - 1);

  logic          rst_n_i;
  logic          strobe;
  logic [AW-1:0] wr_ptr;
  logic          full;
  logic [2:0]    sel_idx;
  logic [AW:0]   dly_len;
  logic [AW-1:0] rd_addr;
  logic [DW-1:0] rd_data;

  logic          upd_q, upd_d;
  logic          valid_q, valid_d;
  logic [DW-1:0] dac_q, dac_d;

  adly_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  adly_tick_gen #(.DIV(DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .strobe (strobe)
  );

  adly_ring_ptr #(.AW(AW)) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .step   (strobe),
    .wr_ptr (wr_ptr),
    .full   (full)
  );

  // Delay length in samples, one of eight multiples of STEP.
  always_comb begin
    sel_idx = sel_index(dly_pin0, dly_pin1, dly_pin2);
    dly_len = (AW+1)'((int'(sel_idx) + 1) * STEP);
    rd_addr = wr_ptr - dly_len[AW-1:0];
  end

  adly_sample_ram #(.DW(DW), .AW(AW)) u_ram (
    .clk    (clk),
    .acc_en (strobe),
    .waddr  (wr_ptr),
    .wdata  (smp_in),
    .raddr  (rd_addr),
    .rdata  (rd_data)
  );

  always_comb begin
    upd_d   = strobe;
    valid_d = valid_q;
    dac_d   = dac_q;
    if (strobe) valid_d = full;
    if (upd_q)  dac_d   = valid_q ? rd_data : MID;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      upd_q   <= 1'b0;
      valid_q <= 1'b0;
      dac_q   <= MID;
    end else begin
      upd_q   <= upd_d;
      valid_q <= valid_d;
      dac_q   <= dac_d;
    end
  end

  assign smp_strobe = strobe;
  assign dac_out    = dac_q;

  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n_i)
    !upd_q |=> $stable(dac_q)); // R7
  AST_UPD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n_i)
    strobe |=> upd_q); // R7
  AST_MID_UNTIL_FULL: assert property (@(posedge clk) disable iff (!rst_n_i)
    (upd_q && !valid_q) |=> (dac_q == MID)); // R6
  AST_STROBE_IN_RESET: assert property (@(posedge clk)
    !rst_n_i |-> !smp_strobe); // R6
endmodule

// File: tb/sim_adly_top.sv
module sim_adly_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 4;
  localparam int DW    = 8;
  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;
  localparam int STEP  = DEPTH / 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [DW-1:0] smp_in;
  logic          dly_pin0, dly_pin1, dly_pin2;
  logic          smp_strobe;
  logic [DW-1:0] dac_out;

  adly_top #(.DIV(DIV), .DW(DW), .AW(AW)) u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .smp_in     (smp_in),
    .dly_pin0   (dly_pin0),
    .dly_pin1   (dly_pin1),
    .dly_pin2   (dly_pin2),
    .smp_strobe (smp_strobe),
    .dac_out    (dac_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, expv, $time);
    end
  endtask

  // Behavioural reference: history of every sample written since reset.
  int hist[$];
  int k, exp_cur, pend_cnt, pend_val, gap;
  bit seen;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(dac_out == 8'h80, "R6 reset output", int'(dac_out), 128);
      chk(smp_strobe == 1'b0, "R6 reset strobe", int'(smp_strobe), 0);
      hist.delete();
      k = 0; exp_cur = 128; pend_cnt = 0; pend_val = 0; gap = 0; seen = 0;
    end else begin
      if (pend_cnt > 0) begin
        pend_cnt--;
        if (pend_cnt == 0) exp_cur = pend_val;
      end
      if (k <= DEPTH)
        chk(dac_out == DW'(exp_cur), "R6 midscale/R7 hold", int'(dac_out), exp_cur);
      else
        chk(dac_out == DW'(exp_cur), "R3 delayed sample/R7 hold", int'(dac_out), exp_cur);
      gap++;
      if (smp_strobe) begin
        if (seen) chk(gap == DIV, "R1 strobe spacing", gap, DIV);
        else      chk(gap <= DIV + 4, "R1 first strobe", gap, DIV + 4);
        seen = 1;
        gap = 0;
        k++;
        hist.push_back(int'(smp_in));
        begin
          int idx, n;
          idx = dly_pin1 * 4 + dly_pin2 * 2 + dly_pin0;   // R5 weights
          n = STEP * (idx + 1);                          // R4 length
          pend_val = (k - 1 >= DEPTH) ? hist[k - 1 - n] : 128;
        end
        pend_cnt = 2;
      end else if (seen) begin
        chk(gap < DIV, "R1 no strobe inside period", gap, DIV - 1);
      end
    end
  end

  task automatic run(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      #1;
      smp_in = 8'($urandom);
    end
  endtask

  task automatic set_sel(input int idx);
    dly_pin1 = idx[2];
    dly_pin2 = idx[1];
    dly_pin0 = idx[0];
  endtask

  initial begin
    rst_n = 1'b0;
    smp_in = '0;
    set_sel(0);
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    // R2 R3 R4 R5 R8: step through all eight settings, changing mid-stream.
    for (int s = 0; s < 8; s++) begin
      set_sel(s);
      run(100 * DIV + 1);
    end
    // R5: single-pin settings out of order.
    set_sel(4); run(40 * DIV);
    set_sel(2); run(40 * DIV + 2);
    set_sel(1); run(40 * DIV);
    // R6 R9: mid-run reset, then full-depth delay across the fill boundary.
    #2 rst_n = 1'b0;
    run(4);
    set_sel(7);
    #1 rst_n = 1'b1;
    run((DEPTH + 40) * DIV);
    // R8: shrink the delay after the buffer is full.
    set_sel(0); run(30 * DIV);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule